// File: doc/BRIEF.md
# Prioritized Interrupt Controller Register File

This block sits between a set of hardware interrupt lines and a processor core. For each of `NUM_IRQ` interrupts it holds an enable bit, a pending bit, an active bit and a priority field. Software reaches all of this state through a simple 32-bit word-addressed write/read port. Enable and pending bits are never written directly. Each has a bank that sets bits (every 1 in the data sets the bit) and a bank that clears bits (every 1 in the data clears the bit). A 0 in the data leaves the bit as it was.

From the interrupts that are enabled, pending and not active, the block picks the most urgent one. It raises a request toward the core only when that interrupt is strictly more urgent than every interrupt already being serviced. The core takes the interrupt with an acknowledge strobe and retires it with an end-of-interrupt strobe that carries the interrupt number.

Top module: `irq_ctrl_regs`

## Requirements
- R1: After a synchronous active-low reset, all enable, pending, active and priority state is zero, `irq_req` is low and every bank reads as zero.
- R2: Interrupt n lives in 32-bit word n/32 of each bit bank, at bit n%32. A word write to the enable-set bank (byte address 0x000 + 4·w) sets the enable bits under the 1s in the data. A write to the enable-clear bank (0x080 + 4·w) clears them. 0 bits have no effect. Reading either bank returns the enable state.
- R3: The pending-set bank (0x100 + 4·w) and the pending-clear bank (0x180 + 4·w) do the same for the pending bits. Reading either bank returns the pending state.
- R4: The active bank (0x200 + 4·w) is read-only, and writes to it change nothing.
- R5: The priority of interrupt n sits in the word at 0x400 + 4·(n/4), bits (n%4)·8+7 down to (n%4)·8. A write changes only the fields whose byte enable (`bus_be` bit n%4) is 1.
- R6: Only the upper `PRIO_BITS` bits of each priority byte (default 3) are stored. The lower bits read as 0 and take no part in arbitration, so written values such as 1 and 2 rank equally.
- R7: Among the interrupts that are enabled, pending and not active, the one with the numerically lowest stored priority wins. On a tie, the lower interrupt number wins. `irq_id` shows the winner combinationally.
- R8: `irq_req` is high only when a winner exists and its priority is strictly lower in value than the priority of every active interrupt.
- R9: When `irq_ack` is high while `irq_req` is high, the next clock edge clears the pending bit of `irq_id` and sets its active bit. When `irq_ack` is high while `irq_req` is low, it has no effect.
- R10: When `irq_eoi` is high, the next clock edge clears the active bit of interrupt `irq_eoi_id`.
- R11: A rising edge on `irq_line[n]` sets pending bit n at the next clock edge. A line that stays high does not set the bit again after software clears it.
- R12: If a rising edge on `irq_line[n]` and a pending-clear write to bit n fall in the same cycle, the pending bit ends up set.
- R13: Reserved addresses ignore writes and read as zero. These are 0x280–0x3FF, 0x600–0xFFF, bit-bank words at or above ceil(NUM_IRQ/32), and priority words at or above ceil(NUM_IRQ/4).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_line | input | NUM_IRQ | Hardware interrupt lines, rising edge sets pending |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | 12 | Byte address; bits 1:0 are ignored |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte enables; used by priority words only |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq_req | output | 1 | Request to the core |
| irq_id | output | $clog2(NUM_IRQ) | Number of the selected interrupt |
| irq_ack | input | 1 | Core acknowledge of `irq_id` |
| irq_eoi | input | 1 | End-of-interrupt strobe |
| irq_eoi_id | input | $clog2(NUM_IRQ) | Number of the interrupt being retired |

## Verification
Every state change lands on the clock edge that samples the write, acknowledge, end-of-interrupt or line edge. Read data and the request/ID pair are combinational from that state, so each result is due one edge after its stimulus. The bench drives stimulus on the falling edge. It holds the stimulus across exactly one rising edge, then samples `bus_rdata`, `irq_req` and `irq_id` shortly after the next falling edge, before any new stimulus is applied. Checks that something is ignored read the affected bank back in that same window.

// File: rtl/irq_ctrl_pkg.sv
// Package: address regions and decode helper shared by the interrupt controller.
// Assumes a 12-bit byte address with word granularity (bits 1:0 ignored).
package irq_ctrl_pkg;

    typedef enum logic [2:0] {
        RG_EN_SET  = 3'd0,
        RG_EN_CLR  = 3'd1,
        RG_PD_SET  = 3'd2,
        RG_PD_CLR  = 3'd3,
        RG_ACTIVE  = 3'd4,
        RG_PRIO    = 3'd5,
        RG_NONE    = 3'd6
    } region_e;

    // Map a byte address to its register region (word-range limits are applied by the caller).
    function automatic region_e addr_region(input logic [11:0] a);
        if (a[11:9] == 3'b010)
            return RG_PRIO;
        case (a[11:7])
            5'd0:    return RG_EN_SET;
            5'd1:    return RG_EN_CLR;
            5'd2:    return RG_PD_SET;
            5'd3:    return RG_PD_CLR;
            5'd4:    return RG_ACTIVE;
            default: return RG_NONE;
        endcase
    endfunction

endpackage

// File: rtl/irq_bit_state.sv
// Module: per-interrupt enable, pending and active flags plus line edge detection.
// Assumes set/clear masks arrive already decoded to one bit per interrupt.
// A pending set (software or line edge) wins over a clear; acknowledge wins over retire.
module irq_bit_state #(
    parameter int N = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] en_set,
    input  logic [N-1:0] en_clr,
    input  logic [N-1:0] pd_set,
    input  logic [N-1:0] pd_clr,
    input  logic [N-1:0] ack_mask,
    input  logic [N-1:0] eoi_mask,
    input  logic [N-1:0] hw_line,
    output logic [N-1:0] en_q,
    output logic [N-1:0] pd_q,
    output logic [N-1:0] act_q
);

    logic [N-1:0] line_q;
    logic [N-1:0] rise;

    // Rising-edge detect of the hardware lines.
    assign rise = hw_line & ~line_q;

    // Flag update: clears first, then sets so that sets take precedence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            pd_q   <= '0;
            act_q  <= '0;
            line_q <= '0;
        end else begin
            en_q   <= (en_q & ~en_clr) | en_set;
            pd_q   <= (pd_q & ~pd_clr & ~ack_mask) | pd_set | rise;
            act_q  <= (act_q & ~eoi_mask) | ack_mask;
            line_q <= hw_line;
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_chk
        // R9: an acknowledged interrupt is active after the edge
        a_r9_ack_sets_active: assert property (@(posedge clk) disable iff (!rst_n)
            ack_mask[i] |=> act_q[i]);
        // R10: retiring without a simultaneous acknowledge leaves it inactive
        a_r10_eoi_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (eoi_mask[i] && !ack_mask[i]) |=> !act_q[i]);
        // R12: a line edge always leaves the pending bit set, even against a clear
        a_r12_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
            (hw_line[i] && !line_q[i]) |=> pd_q[i]);
        // R3: a clear with no competing set removes the pending bit
        a_r3_clear_pending: assert property (@(posedge clk) disable iff (!rst_n)
            (pd_clr[i] && !pd_set[i] && !(hw_line[i] && !line_q[i])) |=> !pd_q[i]);
    end

endmodule

// File: rtl/irq_prio_store.sv
// Module: priority fields, PB bits per interrupt, packed four per bus word.
// Assumes the caller gives a validated write strobe and word index; byte enables select lanes.
module irq_prio_store #(
    parameter int N  = 64,
    parameter int PB = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [6:0]           word_idx,
    input  logic [31:0]          wdata,
    input  logic [3:0]           be,
    output logic [N-1:0][PB-1:0] prio_q
);

    for (genvar i = 0; i < N; i++) begin : g_field
        localparam int LANE = i % 4;
        localparam int WORD = i / 4;
        logic hit;

        // Field select: matching word and its own byte lane enabled.
        assign hit = wr_en && (int'(word_idx) == WORD) && be[LANE];

        // Field storage: keep only the upper PB bits of the written byte.
        always_ff @(posedge clk) begin
            if (!rst_n)
                prio_q[i] <= '0;
            else if (hit)
                prio_q[i] <= wdata[LANE*8+7 -: PB];
        end

        // R5: a field whose lane or word is not written keeps its value
        a_r5_lane_isolated: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && (int'(word_idx) == WORD) && be[LANE]) |=> $stable(prio_q[i]));
    end

endmodule

// File: rtl/irq_pick.sv
// Module: selects the most urgent eligible interrupt and gates the request
// against the most urgent active one. Lower value wins, lower number breaks ties.
// Assumes N >= 2; the scan is a linear priority chain.
module irq_pick #(
    parameter int N  = 64,
    parameter int PB = 3,
    localparam int IDW = $clog2(N)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N-1:0]         en,
    input  logic [N-1:0]         pend,
    input  logic [N-1:0]         act,
    input  logic [N-1:0][PB-1:0] prio,
    output logic                 req,
    output logic [IDW-1:0]       id
);

    logic [N-1:0]  cand;
    logic          found;
    logic [PB-1:0] best_p;
    logic [PB:0]   ceil_p;

    // Eligible set: enabled, pending and not in service.
    assign cand = en & pend & ~act;

    // Winner scan: strict compare keeps the lowest number on equal priority.
    always_comb begin
        found  = 1'b0;
        best_p = '1;
        id     = '0;
        for (int i = 0; i < N; i++) begin
            if (cand[i] && (!found || prio[i] < best_p)) begin
                found  = 1'b1;
                best_p = prio[i];
                id     = IDW'(i);
            end
        end
    end

    // Ceiling scan: most urgent active priority, or one past the range when none is active.
    always_comb begin
        ceil_p = {1'b1, {PB{1'b0}}};
        for (int i = 0; i < N; i++) begin
            if (act[i] && ({1'b0, prio[i]} < ceil_p))
                ceil_p = {1'b0, prio[i]};
        end
    end

    // Request gate: strictly more urgent than the ceiling.
    assign req = found && ({1'b0, best_p} < ceil_p);

    // R7: a request always names an eligible interrupt
    a_r7_id_eligible: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> (en[id] && pend[id] && !act[id]));
    // R8: nothing is requested while every eligible interrupt is blocked
    a_r8_no_req_without_cand: assert property (@(posedge clk) disable iff (!rst_n)
        (cand == '0) |-> !req);

endmodule

// File: rtl/irq_ctrl_regs.sv
// Module: top of the interrupt controller. Decodes the register port into
// set/clear masks, returns read data, and connects state, priorities and picker.
// Assumes 2 <= NUM_IRQ <= 512 and 1 <= PRIO_BITS <= 8.
module irq_ctrl_regs
    import irq_ctrl_pkg::*;
#(
    parameter int NUM_IRQ   = 64,
    parameter int PRIO_BITS = 3,
    localparam int IDW      = $clog2(NUM_IRQ)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] irq_line,
    input  logic               bus_wr,
    input  logic [11:0]        bus_addr,
    input  logic [31:0]        bus_wdata,
    input  logic [3:0]         bus_be,
    output logic [31:0]        bus_rdata,
    output logic               irq_req,
    output logic [IDW-1:0]     irq_id,
    input  logic               irq_ack,
    input  logic               irq_eoi,
    input  logic [IDW-1:0]     irq_eoi_id
);

    localparam int N_BW = (NUM_IRQ + 31) / 32;
    localparam int N_PW = (NUM_IRQ + 3) / 4;

    region_e                          rg;
    logic [4:0]                       bw_idx;
    logic [6:0]                       pw_idx;
    logic                             bw_ok;
    logic                             pw_ok;
    logic [NUM_IRQ-1:0]               wmask;
    logic [NUM_IRQ-1:0]               en_set, en_clr, pd_set, pd_clr;
    logic [NUM_IRQ-1:0]               ack_mask, eoi_mask;
    logic [NUM_IRQ-1:0]               en_q, pd_q, act_q;
    logic [NUM_IRQ-1:0][PRIO_BITS-1:0] prio_q;

    // Address decode: region plus word index, range-checked against the interrupt count.
    assign rg     = addr_region(bus_addr);
    assign bw_idx = bus_addr[6:2];
    assign pw_idx = bus_addr[8:2];
    assign bw_ok  = int'(bw_idx) < N_BW;
    assign pw_ok  = int'(pw_idx) < N_PW;

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_mask
        // Data bit routed to interrupt i when its word is addressed.
        assign wmask[i]    = bus_wdata[i % 32] && (int'(bw_idx) == i / 32);
        // Core handshake decoded to one-hot per interrupt.
        assign ack_mask[i] = irq_ack && irq_req && (irq_id == IDW'(i));
        assign eoi_mask[i] = irq_eoi && (irq_eoi_id == IDW'(i));
    end

    // Bank write masks: only valid bit-bank words of the matching region.
    assign en_set = (bus_wr && bw_ok && rg == RG_EN_SET) ? wmask : '0;
    assign en_clr = (bus_wr && bw_ok && rg == RG_EN_CLR) ? wmask : '0;
    assign pd_set = (bus_wr && bw_ok && rg == RG_PD_SET) ? wmask : '0;
    assign pd_clr = (bus_wr && bw_ok && rg == RG_PD_CLR) ? wmask : '0;

    irq_bit_state #(.N(NUM_IRQ)) u_state (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_set   (en_set),
        .en_clr   (en_clr),
        .pd_set   (pd_set),
        .pd_clr   (pd_clr),
        .ack_mask (ack_mask),
        .eoi_mask (eoi_mask),
        .hw_line  (irq_line),
        .en_q     (en_q),
        .pd_q     (pd_q),
        .act_q    (act_q)
    );

    irq_prio_store #(.N(NUM_IRQ), .PB(PRIO_BITS)) u_prio (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_wr && pw_ok && rg == RG_PRIO),
        .word_idx (pw_idx),
        .wdata    (bus_wdata),
        .be       (bus_be),
        .prio_q   (prio_q)
    );

    irq_pick #(.N(NUM_IRQ), .PB(PRIO_BITS)) u_pick (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en_q),
        .pend  (pd_q),
        .act   (act_q),
        .prio  (prio_q),
        .req   (irq_req),
        .id    (irq_id)
    );

    // Read mux: bit banks by word, priorities left-aligned in their byte lanes, zero elsewhere.
    always_comb begin
        bus_rdata = '0;
        case (rg)
            RG_EN_SET, RG_EN_CLR: begin
                for (int i = 0; i < NUM_IRQ; i++)
                    if (bw_ok && int'(bw_idx) == i / 32) bus_rdata[i % 32] = en_q[i];
            end
            RG_PD_SET, RG_PD_CLR: begin
                for (int i = 0; i < NUM_IRQ; i++)
                    if (bw_ok && int'(bw_idx) == i / 32) bus_rdata[i % 32] = pd_q[i];
            end
            RG_ACTIVE: begin
                for (int i = 0; i < NUM_IRQ; i++)
                    if (bw_ok && int'(bw_idx) == i / 32) bus_rdata[i % 32] = act_q[i];
            end
            RG_PRIO: begin
                for (int i = 0; i < NUM_IRQ; i++)
                    if (pw_ok && int'(pw_idx) == i / 4)
                        bus_rdata[(i % 4)*8 + 7 -: PRIO_BITS] = prio_q[i];
            end
            default: bus_rdata = '0;
        endcase
    end

    // R4: a write aimed at the active bank never changes the active flags
    a_r4_active_readonly: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && rg == RG_ACTIVE && !irq_ack && !irq_eoi) |=> $stable(act_q));
    // R13: reserved regions read as zero
    a_r13_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rg == RG_NONE) |-> (bus_rdata == 32'h0));

endmodule

// File: tb/sim_irq_ctrl_regs.sv
module sim_irq_ctrl_regs;

    localparam int NI  = 64;
    localparam int IDW = $clog2(NI);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NI-1:0]   irq_line = '0;
    logic            bus_wr = 1'b0;
    logic [11:0]     bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [3:0]      bus_be = 4'hF;
    logic [31:0]     bus_rdata;
    logic            irq_req;
    logic [IDW-1:0]  irq_id;
    logic            irq_ack = 1'b0;
    logic            irq_eoi = 1'b0;
    logic [IDW-1:0]  irq_eoi_id = '0;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    irq_ctrl_regs #(.NUM_IRQ(NI), .PRIO_BITS(3)) u0 (
        .clk(clk), .rst_n(rst_n), .irq_line(irq_line),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_be(bus_be),
        .bus_rdata(bus_rdata), .irq_req(irq_req), .irq_id(irq_id),
        .irq_ack(irq_ack), .irq_eoi(irq_eoi), .irq_eoi_id(irq_eoi_id)
    );

    // Vector: {is_read, addr[12], data[32], be[4], expect[32]}
    localparam int NV = 27;
    localparam logic [80:0] VT [NV] = '{
        {1'b1, 12'h000, 32'h0, 4'hF, 32'h0000_0000},  // R1 reset
        {1'b1, 12'h104, 32'h0, 4'hF, 32'h0000_0000},  // R1 reset
        {1'b1, 12'h400, 32'h0, 4'hF, 32'h0000_0000},  // R1 reset
        {1'b0, 12'h000, 32'h8000_0005, 4'hF, 32'h0},  // R2 set 0,2,31
        {1'b1, 12'h000, 32'h0, 4'hF, 32'h8000_0005},  // R2
        {1'b1, 12'h080, 32'h0, 4'hF, 32'h8000_0005},  // R2 clear bank reads state
        {1'b0, 12'h000, 32'h0000_0000, 4'hF, 32'h0},  // R2 zeros no effect
        {1'b1, 12'h000, 32'h0, 4'hF, 32'h8000_0005},  // R2
        {1'b0, 12'h080, 32'h0000_0004, 4'hF, 32'h0},  // R2 clear 2
        {1'b1, 12'h000, 32'h0, 4'hF, 32'h8000_0001},  // R2
        {1'b0, 12'h004, 32'h0000_0100, 4'hF, 32'h0},  // R2 irq 40
        {1'b1, 12'h084, 32'h0, 4'hF, 32'h0000_0100},  // R2
        {1'b0, 12'h200, 32'hFFFF_FFFF, 4'hF, 32'h0},  // R4
        {1'b1, 12'h200, 32'h0, 4'hF, 32'h0000_0000},  // R4
        {1'b0, 12'h400, 32'hE040_2221, 4'hF, 32'h0},  // R6
        {1'b1, 12'h400, 32'h0, 4'hF, 32'hE040_2020},  // R6 low bits dropped
        {1'b0, 12'h400, 32'h1111_6611, 4'h2, 32'h0},  // R5 lane 1 only
        {1'b1, 12'h400, 32'h0, 4'hF, 32'hE040_6020},  // R5
        {1'b0, 12'h100, 32'h0000_0030, 4'hF, 32'h0},  // R3 pend 4,5
        {1'b1, 12'h180, 32'h0, 4'hF, 32'h0000_0030},  // R3
        {1'b0, 12'h180, 32'h0000_0010, 4'hF, 32'h0},  // R3 clear 4
        {1'b1, 12'h100, 32'h0, 4'hF, 32'h0000_0020},  // R3
        {1'b0, 12'h300, 32'hFFFF_FFFF, 4'hF, 32'h0},  // R13
        {1'b1, 12'h300, 32'h0, 4'hF, 32'h0000_0000},  // R13
        {1'b0, 12'h008, 32'hFFFF_FFFF, 4'hF, 32'h0},  // R13 word beyond count
        {1'b1, 12'h008, 32'h0, 4'hF, 32'h0000_0000},  // R13
        {1'b1, 12'h000, 32'h0, 4'hF, 32'h8000_0001}   // R13 real bank untouched
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
        @(negedge clk);
        bus_wr = 1'b0; bus_be = 4'hF;
    endtask

    task automatic rd(input string tag, input logic [11:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic req_chk(input string tag, input logic r, input logic [IDW-1:0] i);
        @(negedge clk);
        #1;
        chk({tag, " req"}, {31'b0, irq_req}, {31'b0, r});
        if (r) chk({tag, " id"}, {{(32-IDW){1'b0}}, irq_id}, {{(32-IDW){1'b0}}, i});
    endtask

    task automatic ack_pulse();
        @(negedge clk); irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0;
    endtask

    task automatic eoi_pulse(input logic [IDW-1:0] k);
        @(negedge clk); irq_eoi = 1'b1; irq_eoi_id = k;
        @(negedge clk); irq_eoi = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        req_chk("R1", 1'b0, '0);

        // Table walk
        for (int k = 0; k < NV; k++) begin
            if (VT[k][80])
                rd($sformatf("table[%0d]", k), VT[k][79:68], VT[k][31:0]);
            else
                wr(VT[k][79:68], VT[k][67:36], VT[k][35:32]);
        end

        // Clean slate for arbitration tests
        wr(12'h080, 32'hFFFF_FFFF, 4'hF); wr(12'h084, 32'hFFFF_FFFF, 4'hF);
        wr(12'h180, 32'hFFFF_FFFF, 4'hF); wr(12'h184, 32'hFFFF_FFFF, 4'hF);
        for (int w = 0; w < 16; w++) wr(12'h400 + 12'(w*4), 32'h0, 4'hF);

        // R7: irq3=0x40, irq9=0x20, irq12=0x20 -> 9 wins the tie
        wr(12'h400, 32'h4000_0000, 4'h8);
        wr(12'h408, 32'h0000_2000, 4'h2);
        wr(12'h40C, 32'h0000_0020, 4'h1);
        wr(12'h000, 32'h0000_1208, 4'hF);
        wr(12'h100, 32'h0000_1208, 4'hF);
        req_chk("R7", 1'b1, IDW'(9));

        // R6: 0x02 and 0x01 both store as zero -> tie, lower number wins
        wr(12'h408, 32'h0000_0200, 4'h2);
        wr(12'h40C, 32'h0000_0001, 4'h1);
        req_chk("R6", 1'b1, IDW'(9));
        rd("R6 readback", 12'h40C, 32'h0000_0000);

        // R9: acknowledge moves 9 from pending to active
        ack_pulse();
        rd("R9 active", 12'h200, 32'h0000_0200);
        rd("R9 pending", 12'h100, 32'h0000_1008);
        // R8: 12 has equal priority to active 9 -> blocked
        req_chk("R8", 1'b0, '0);
        // R9: acknowledge without request ignored
        ack_pulse();
        rd("R9 ignored", 12'h200, 32'h0000_0200);

        // R10: retire 9 -> 12 requested
        eoi_pulse(IDW'(9));
        rd("R10 active", 12'h200, 32'h0000_0000);
        req_chk("R10", 1'b1, IDW'(12));
        ack_pulse();
        req_chk("R8 lower urgency", 1'b0, '0);
        eoi_pulse(IDW'(12));
        req_chk("R8 release", 1'b1, IDW'(3));
        ack_pulse();
        eoi_pulse(IDW'(3));
        req_chk("R10 idle", 1'b0, '0);

        // R11: rising edge on line 20 sets pending
        wr(12'h000, 32'h0010_0000, 4'hF);
        @(negedge clk) irq_line[20] = 1'b1;
        rd("R11 edge", 12'h100, 32'h0010_0000);
        req_chk("R11", 1'b1, IDW'(20));
        wr(12'h180, 32'h0010_0000, 4'hF);
        rd("R11 level no re-pend", 12'h100, 32'h0000_0000);

        // R12: new edge and clear in the same cycle -> set wins
        @(negedge clk) irq_line[20] = 1'b0;
        @(negedge clk);
        irq_line[20] = 1'b1;
        bus_wr = 1'b1; bus_addr = 12'h180; bus_wdata = 32'h0010_0000;
        @(negedge clk) bus_wr = 1'b0;
        rd("R12", 12'h100, 32'h0010_0000);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule